// File: doc/BRIEF.md
# Interrupt Source PQ State Controller

This block holds a two-bit pending/queued (PQ) state for each of a set of interrupt sources. Hardware raises events on a per-source trigger vector. Software reaches each source through a small management page, using a source index, a 12-bit page offset and a load or store flag. Loads in certain offset regions return the previous PQ value and force a new one. A load in another region performs an end-of-interrupt (EOI). A store in its own region performs an EOI on a posted, lower-latency path. Whenever a source's state machine decides that the router has to see the interrupt, the block pulses that source's notification output.

Each source is a four-state machine: IDLE (00), OFF (01), PENDING (10) and QUEUED (11).
- Trigger: IDLE goes to PENDING and notifies. PENDING and QUEUED both go to QUEUED. OFF absorbs the trigger.
- EOI: PENDING goes to IDLE. QUEUED goes to PENDING and notifies again.
- Set-PQ load: forces any of the four states.

Store EOIs are posted into a queue. Each entry at the head of the queue takes effect a fixed number of cycles later. A port state machine with two states, OPEN and FENCED, holds back an ordered load until the queue is empty:
- OPEN goes to FENCED when an ordered load meets a non-empty queue.
- FENCED goes back to OPEN once the queue is empty.

Top module: `irq_pq_ctrl`

## Requirements
- R1: After reset every source is OFF (01), `sw_ready_o` is high for an idle port, and `rsp_valid_o` and `notify_o` are low.
- R2: A trigger moves IDLE to PENDING and pulses that source's notify. It moves PENDING or QUEUED to QUEUED without a notify. It leaves OFF unchanged, with no notify.
- R3: A load whose effective offset bits [11:8] equal 0x0 is an EOI. PENDING goes to IDLE. QUEUED goes to PENDING and notifies again. The response is {0, old Q}.
- R4: Loads in regions 0xC, 0xD, 0xE and 0xF (offset bits [11:8]) set PQ to 00, 01, 10 and 11 respectively. They return the old PQ, with P in bit 1 and Q in bit 0.
- R5: `rsp_valid_o` is high for exactly the cycle after a load is accepted. A load in any other region returns 00 and leaves the state unchanged.
- R6: A store in region 0x4 to a source whose `cfg_store_eoi_i` bit is set is queued, and later applies the EOI transitions of R3. Any other store has no effect on PQ.
- R7: The store queue holds QDEPTH entries, and a store is held (ready low) while the queue is full. The head entry is applied DRAIN_CYC cycles after it reaches the head. If a load is accepted in that cycle, the head entry is deferred.
- R8: A load with bit 6 of its effective offset set is not accepted until the store queue is empty, so it sees every earlier store EOI. A load without that bit is accepted at once and can observe state from before a queued store EOI.
- R9: For a source whose `cfg_quirk_i` bit is set, the effective offset is the offset ORed with itself shifted left by 4, truncated to 12 bits. For all other sources it is the offset unchanged.
- R10: A notify pulse lasts one cycle. It appears in the cycle after the clock edge that makes the state transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NUM_SRC | Per-source hardware trigger pulses |
| cfg_store_eoi_i | input | NUM_SRC | Per-source enable for store EOI |
| cfg_quirk_i | input | NUM_SRC | Per-source shifted-offset addressing |
| sw_req_i | input | 1 | Software access request |
| sw_store_i | input | 1 | 1 = store, 0 = load |
| sw_src_i | input | SRC_W | Source index of the access |
| sw_off_i | input | 12 | Page offset of the access |
| sw_ready_o | output | 1 | Access accepted on this edge when high with the request |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_pq_o | output | 2 | Load response data |
| notify_o | output | NUM_SRC | Per-source notification pulses to the router |

## Verification
The assertions assume that a requester keeps `sw_req_i` and all of its command fields steady until `sw_ready_o` accepts the access. This matters most for the FENCED state, which waits for the ordered load it was entered for. The bench drives each access from a task that holds the command until acceptance and only then drops it, starting on the falling clock edge. Triggers are single-cycle pulses issued while no other access is pending on the same source.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

    localparam int OFF_W     = 12;
    localparam int ORDER_BIT = 6;
    localparam logic [3:0] RGN_LOAD_EOI  = 4'h0;
    localparam logic [3:0] RGN_STORE_EOI = 4'h4;

    typedef enum logic [1:0] {
        PQ_IDLE   = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_state_e;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_EOI,
        OPK_SET,
        OPK_STORE_EOI
    } op_kind_e;

    typedef enum logic {
        PORT_OPEN,
        PORT_FENCED
    } port_state_e;

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
    import irq_pq_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    input  logic             quirk_i,
    input  logic             store_i,
    output op_kind_e         kind_o,
    output logic [1:0]       set_val_o,
    output logic             ordered_o
);

    logic [OFF_W-1:0] eff;
    logic [3:0]       region;
    logic             unused_bits;

    // R9: shifted-offset sources see offset | (offset << 4)
    assign eff         = quirk_i ? (off_i | (off_i << 4)) : off_i;
    assign region      = eff[OFF_W-1 -: 4];
    assign unused_bits = ^{eff[7], eff[5:0]};
    assign set_val_o   = region[1:0];
    assign ordered_o   = !store_i && eff[ORDER_BIT];

    always_comb begin
        kind_o = OPK_NONE;
        if (store_i) begin
            if (region == RGN_STORE_EOI) kind_o = OPK_STORE_EOI;
        end else begin
            if (region == RGN_LOAD_EOI)    kind_o = OPK_EOI;
            else if (region[3:2] == 2'b11) kind_o = OPK_SET;
        end
    end

endmodule

// File: rtl/irq_pq_cell.sv
module irq_pq_cell
    import irq_pq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       op_en_i,
    input  logic       op_eoi_i,
    input  logic [1:0] op_val_i,
    output logic [1:0] pq_o,
    output logic       notify_o
);

    pq_state_e pq, mid, nxt;
    logic      op_note, trig_note, notify_q;

    // software or drained operation first, trigger applied on top
    always_comb begin
        mid     = pq;
        op_note = 1'b0;
        if (op_en_i) begin
            if (op_eoi_i) begin
                unique case (pq)
                    PQ_PEND:         mid = PQ_IDLE;
                    PQ_QUEUED: begin mid = PQ_PEND; op_note = 1'b1; end
                    PQ_IDLE, PQ_OFF: mid = pq;
                endcase
            end else begin
                mid = pq_state_e'(op_val_i);
            end
        end
    end

    always_comb begin
        nxt       = mid;
        trig_note = 1'b0;
        if (trig_i) begin
            unique case (mid)
                PQ_IDLE:            begin nxt = PQ_PEND; trig_note = 1'b1; end
                PQ_OFF:             nxt = PQ_OFF;
                PQ_PEND, PQ_QUEUED: nxt = PQ_QUEUED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq       <= PQ_OFF;
            notify_q <= 1'b0;
        end else begin
            pq       <= nxt;
            notify_q <= op_note | trig_note;
        end
    end

    assign pq_o     = pq;
    assign notify_o = notify_q;

    a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pq == PQ_OFF && !op_en_i) |=> (pq == PQ_OFF && !notify_q));

    a_r2_trig_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pq == PQ_IDLE && !op_en_i && trig_i) |=> (pq == PQ_PEND && notify_q));

    a_r3_eoi_requeues: assert property (@(posedge clk) disable iff (!rst_n)
        (pq == PQ_QUEUED && op_en_i && op_eoi_i) |=> (notify_q && pq[1]));

endmodule

// File: rtl/irq_pq_store_q.sv
module irq_pq_store_q #(
    parameter int DEPTH     = 4,
    parameter int DW        = 3,
    parameter int DRAIN_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    output logic          full_o,
    output logic          empty_o,
    output logic          due_o,
    output logic [DW-1:0] head_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int LAT_W = $clog2(DRAIN_CYC + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic [LAT_W-1:0] lat;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full_o  = (cnt == CNT_W'(DEPTH));
    assign empty_o = (cnt == '0);
    assign due_o   = !empty_o && (lat == LAT_W'(DRAIN_CYC - 1));
    assign head_o  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            lat    <= '0;
        end else begin
            if (push_i) wr_ptr <= bump(wr_ptr);
            if (pop_i)  rd_ptr <= bump(rd_ptr);
            unique case ({push_i, pop_i})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
            if (pop_i || empty_o) lat <= '0;
            else if (!due_o)      lat <= lat + LAT_W'(1);
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (!push_i || pop_i));

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/irq_pq_ctrl.sv
module irq_pq_ctrl
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int QDEPTH    = 4,
    parameter int DRAIN_CYC = 3,
    localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic [NUM_SRC-1:0] cfg_store_eoi_i,
    input  logic [NUM_SRC-1:0] cfg_quirk_i,
    input  logic               sw_req_i,
    input  logic               sw_store_i,
    input  logic [SRC_W-1:0]   sw_src_i,
    input  logic [OFF_W-1:0]   sw_off_i,
    output logic               sw_ready_o,
    output logic               rsp_valid_o,
    output logic [1:0]         rsp_pq_o,
    output logic [NUM_SRC-1:0] notify_o
);

    op_kind_e    dec_kind;
    logic [1:0]  dec_val;
    logic        dec_ordered;
    logic        q_full, q_empty, q_due;
    logic [SRC_W-1:0] q_head;
    port_state_e port_q, port_d;
    logic        accept, load_acc, push, pop;
    logic        op_en, op_eoi;
    logic [SRC_W-1:0] op_src;
    logic [1:0]  pq_all [NUM_SRC];
    logic        rsp_valid_q;
    logic [1:0]  rsp_pq_q;

    irq_pq_decode u_dec (
        .off_i     (sw_off_i),
        .quirk_i   (cfg_quirk_i[sw_src_i]),
        .store_i   (sw_store_i),
        .kind_o    (dec_kind),
        .set_val_o (dec_val),
        .ordered_o (dec_ordered)
    );

    irq_pq_store_q #(.DEPTH(QDEPTH), .DW(SRC_W), .DRAIN_CYC(DRAIN_CYC)) u_sq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (sw_src_i),
        .pop_i   (pop),
        .full_o  (q_full),
        .empty_o (q_empty),
        .due_o   (q_due),
        .head_o  (q_head)
    );

    // port state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) port_q <= PORT_OPEN;
        else        port_q <= port_d;
    end

    // port state machine: next state and ready
    always_comb begin
        port_d     = port_q;
        sw_ready_o = 1'b1;
        unique case (port_q)
            PORT_OPEN: begin
                if (sw_store_i)       sw_ready_o = !q_full;
                else if (dec_ordered) sw_ready_o = q_empty;
                if (sw_req_i && !sw_store_i && dec_ordered && !q_empty)
                    port_d = PORT_FENCED;
            end
            PORT_FENCED: begin
                sw_ready_o = q_empty;
                if (q_empty) port_d = PORT_OPEN;
            end
        endcase
    end

    assign accept   = sw_req_i && sw_ready_o;
    assign load_acc = accept && !sw_store_i;
    assign push     = accept && sw_store_i && (dec_kind == OPK_STORE_EOI)
                      && cfg_store_eoi_i[sw_src_i];
    assign pop      = q_due && !load_acc;

    // one state operation per cycle: accepted load wins over the drain
    always_comb begin
        op_en  = 1'b0;
        op_eoi = 1'b0;
        op_src = sw_src_i;
        if (load_acc && (dec_kind == OPK_EOI || dec_kind == OPK_SET)) begin
            op_en  = 1'b1;
            op_eoi = (dec_kind == OPK_EOI);
        end else if (pop) begin
            op_en  = 1'b1;
            op_eoi = 1'b1;
            op_src = q_head;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_pq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_i   (trig_i[g]),
            .op_en_i  (op_en && (op_src == SRC_W'(g))),
            .op_eoi_i (op_eoi),
            .op_val_i (dec_val),
            .pq_o     (pq_all[g]),
            .notify_o (notify_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_pq_q    <= 2'b00;
        end else begin
            rsp_valid_q <= load_acc;
            if (load_acc) begin
                unique case (dec_kind)
                    OPK_EOI: rsp_pq_q <= {1'b0, pq_all[sw_src_i][0]};
                    OPK_SET: rsp_pq_q <= pq_all[sw_src_i];
                    default: rsp_pq_q <= 2'b00;
                endcase
            end
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_pq_o    = rsp_pq_q;

    a_r8_fence_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (load_acc && dec_ordered) |-> q_empty);

    a_r6_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !q_empty);

endmodule

// File: tb/irq_pq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_pq_ctrl_tb_top;

    localparam int NSRC  = 8;
    localparam int SRC_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  trig = '0;
    logic [NSRC-1:0]  cfg_seoi = 8'b0000_1000;
    logic [NSRC-1:0]  cfg_quirk = 8'b0010_0000;
    logic             sw_req = 1'b0, sw_store = 1'b0;
    logic [SRC_W-1:0] sw_src = '0;
    logic [11:0]      sw_off = '0;
    logic             sw_ready_o, rsp_valid_o;
    logic [1:0]       rsp_pq_o;
    logic [NSRC-1:0]  notify_o;

    int total = 0, bad = 0;
    int ncount [NSRC];

    always #10 clk = ~clk;

    irq_pq_ctrl #(.NUM_SRC(NSRC), .QDEPTH(4), .DRAIN_CYC(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .cfg_store_eoi_i(cfg_seoi), .cfg_quirk_i(cfg_quirk),
        .sw_req_i(sw_req), .sw_store_i(sw_store), .sw_src_i(sw_src),
        .sw_off_i(sw_off), .sw_ready_o(sw_ready_o),
        .rsp_valid_o(rsp_valid_o), .rsp_pq_o(rsp_pq_o), .notify_o(notify_o)
    );

    initial for (int i = 0; i < NSRC; i++) ncount[i] = 0;
    always @(negedge clk)
        for (int i = 0; i < NSRC; i++) if (notify_o[i]) ncount[i]++;

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic access(input logic st, input int src, input logic [11:0] off,
                          output logic [1:0] data, output logic rv, output int stalls);
        sw_req = 1'b1; sw_store = st; sw_src = SRC_W'(src); sw_off = off;
        stalls = 0;
        #1;
        while (!sw_ready_o) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        data = rsp_pq_o; rv = rsp_valid_o;
        sw_req = 1'b0; sw_store = 1'b0;
    endtask

    task automatic ld(input int src, input logic [11:0] off, input int exp, input string tag);
        logic [1:0] d; logic v; int s;
        access(1'b0, src, off, d, v, s);
        check(int'(v), 1, "R5 response valid after load");
        check(int'(d), exp, tag);
    endtask

    task automatic st(input int src, input logic [11:0] off);
        logic [1:0] d; logic v; int s;
        access(1'b1, src, off, d, v, s);
        check(int'(v), 0, "R6 store gives no response");
    endtask

    task automatic pulse(input int src);
        trig[src] = 1'b1;
        @(negedge clk);
        trig = '0;
    endtask

    task automatic t_reset;
        check(int'(sw_ready_o), 1, "R1 ready after reset");
        check(int'(rsp_valid_o), 0, "R1 no response after reset");
        check(int'(notify_o), 0, "R1 no notify after reset");
        ld(0, 12'hC00, 1, "R1 reset state OFF");
    endtask

    task automatic t_trigger;
        int c;
        c = ncount[1]; pulse(1); idle(2);
        check(ncount[1] - c, 0, "R2 trigger on OFF silent");
        ld(1, 12'hC00, 1, "R2 OFF unchanged by trigger");
        c = ncount[0]; pulse(0); idle(2);
        check(ncount[0] - c, 1, "R2 R10 trigger on IDLE notifies once");
        c = ncount[0]; pulse(0); idle(2);
        check(ncount[0] - c, 0, "R2 trigger on PENDING silent");
    endtask

    task automatic t_load_eoi;
        int c;
        c = ncount[0]; ld(0, 12'h000, 1, "R3 EOI from QUEUED returns Q"); idle(2);
        check(ncount[0] - c, 1, "R3 EOI from QUEUED renotifies");
        c = ncount[0]; ld(0, 12'h000, 0, "R3 EOI from PENDING returns 0"); idle(2);
        check(ncount[0] - c, 0, "R3 EOI from PENDING silent");
        ld(0, 12'hC00, 0, "R3 state IDLE after EOI");
    endtask

    task automatic t_set_loads;
        ld(2, 12'hF00, 1, "R4 set 11 returns 01");
        ld(2, 12'hE00, 3, "R4 set 10 returns 11");
        ld(2, 12'hD00, 2, "R4 set 01 returns 10");
        ld(2, 12'hC00, 1, "R4 set 00 returns 01");
        ld(2, 12'hF00, 0, "R4 set 11 returns 00");
        ld(2, 12'h800, 0, "R5 unmapped load returns 00");
        ld(2, 12'hE00, 3, "R5 unmapped load left state");
    endtask

    task automatic t_masked;
        int c;
        c = ncount[2]; pulse(2); idle(2);
        check(ncount[2] - c, 0, "R2 trigger while masked silent");
        c = ncount[2]; ld(2, 12'h000, 1, "R3 masked trigger seen as Q"); idle(2);
        check(ncount[2] - c, 1, "R3 masked trigger renotified");
        ld(2, 12'hC00, 2, "R3 masked EOI leaves PENDING");
    endtask

    task automatic t_store_eoi;
        int c;
        ld(3, 12'hC00, 1, "R6 prepare src3");
        pulse(3); idle(1);
        st(3, 12'h400); idle(6);
        ld(3, 12'hD00, 0, "R6 store EOI cleared PENDING");
        ld(3, 12'hF00, 1, "R6 prepare QUEUED");
        c = ncount[3]; st(3, 12'h400); idle(6);
        check(ncount[3] - c, 1, "R6 store EOI renotifies");
        ld(3, 12'hC00, 2, "R6 store EOI QUEUED to PENDING");
    endtask

    task automatic t_store_ignored;
        ld(4, 12'hE00, 1, "R6 prepare src4");
        st(4, 12'h400); idle(6);
        ld(4, 12'hC00, 2, "R6 store EOI disabled ignored");
        ld(3, 12'hE00, 0, "R6 prepare src3 PENDING");
        st(3, 12'h800); idle(6);
        ld(3, 12'hC00, 2, "R6 store outside EOI region ignored");
    endtask

    task automatic t_ordered;
        logic [1:0] d; logic v; int s;
        ld(3, 12'hF00, 0, "R8 prepare QUEUED");
        st(3, 12'h400);
        access(1'b0, 3, 12'hE40, d, v, s);
        check(int'(s > 0), 1, "R8 ordered load held");
        check(int'(d), 2, "R8 ordered load sees store EOI");
        idle(6);
        ld(3, 12'hC00, 2, "R8 state after ordered mask");
        ld(3, 12'hF00, 0, "R8 prepare QUEUED again");
        st(3, 12'h400);
        access(1'b0, 3, 12'hE00, d, v, s);
        check(s, 0, "R8 plain load not held");
        check(int'(d), 3, "R8 plain load sees stale state");
        idle(6);
        ld(3, 12'hC00, 0, "R7 deferred store EOI applied after load");
    endtask

    task automatic t_queue_full;
        logic [1:0] d; logic v; int s; int sum;
        sum = 0;
        for (int k = 0; k < 6; k++) begin
            access(1'b1, 3, 12'h400, d, v, s);
            sum += s;
        end
        check(int'(sum > 0), 1, "R7 store held while queue full");
        idle(30);
        ld(3, 12'hC00, 0, "R7 queue drained to IDLE");
    endtask

    task automatic t_quirk;
        ld(5, 12'h0E0, 1, "R9 shifted offset decoded as set 10");
        ld(5, 12'h0C0, 2, "R9 shifted offset decoded as set 00");
        ld(6, 12'h0C0, 1, "R9 plain source treats 0x0C0 as EOI");
        ld(6, 12'hC00, 1, "R9 plain source EOI on OFF unchanged");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_trigger;
        t_load_eoi;
        t_set_loads;
        t_masked;
        t_store_eoi;
        t_store_ignored;
        t_ordered;
        t_queue_full;
        t_quirk;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule